// File: doc/BRIEF.md
# Exception Prioritizer and Entry Controller

This block sits at the front of the exception path of a 32-bit RISC core that knows seven exception classes. Whenever the pipeline reports an instruction boundary, it looks at the pending requests and drops the ones masked by the current status word. It also drops a prefetch abort whose tagged instruction was flushed. From what remains it grants the most urgent request.

For the granted exception it computes the full entry update in one cycle. The update contains:

- the new status word, with its mode field, state bit and interrupt-disable bits rewritten;
- a copy of the old status word for the saved-status register;
- the return link;
- the vector address, taken from a low or a high vector base;
- one-hot write strobes that select the banked link register and the banked saved-status register of the target mode.

All of this appears on registered outputs one clock after the boundary, together with a single-cycle entry pulse.

Requests that are not granted are not stored. They stay asserted on the inputs and are evaluated again at the next boundary. A lower-priority interrupt that arrives together with a data abort is therefore granted once the abort handler has been entered, as long as it is still unmasked. A reset request is granted even without a boundary, because reset stops the current instruction at once.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Among qualified requests the grant follows this order, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, then undefined and software call at the lowest level. The undefined and software-call requests are never raised together.
- R2: The vector is the base plus an offset. The base is 0xFFFF0000 when `hi_vec_i` is 1 and 0x00000000 otherwise. The offsets are: reset 0x00, undefined 0x04, software call 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C. Offset 0x14 is never produced.
- R3: `new_status_o[4:0]` holds the mode code of the target mode: 0b10011 for reset and software call, 0b11011 for undefined, 0b10111 for either abort, 0b10010 for normal interrupt, 0b10001 for fast interrupt.
- R4: In `new_status_o`, bit 5 is 0 and bit 7 is 1. Bit 6 is 1 for reset and fast interrupt and is copied from `status_i[6]` for every other exception. Bits 31:8 are copied from `status_i`.
- R5: `link_o` is `pc_i`+8 for a data abort and `pc_i`+4 for every other non-reset exception. Here `pc_i` is the faulting instruction for undefined, software call and both aborts, and the next instruction to run for interrupts.
- R6: A normal-interrupt request is ignored while `status_i[7]` is 1, and a fast-interrupt request is ignored while `status_i[6]` is 1.
- R7: A prefetch-abort request is ignored while `pabt_flush_i` is 1.
- R8: A reset request is granted with or without `boundary_i`. It leaves both strobe vectors at zero.
- R9: The strobe vectors `link_we_o` and `psr_we_o` are equal and one-hot during an entry. Bit 0 selects supervisor, bit 1 undefined, bit 2 abort, bit 3 normal interrupt and bit 4 fast interrupt. `saved_status_o` equals the `status_i` sampled at the boundary.
- R10: The outputs update on the clock edge that samples the boundary. `entry_o` is high for exactly one cycle. A boundary or reset request sampled while `entry_o` is high is ignored. When nothing is granted, `entry_o` and all strobes are 0.
- R11: While `rst_n` is low, `entry_o` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| boundary_i | input | 1 | Instruction boundary: requests are evaluated this cycle |
| rq_reset_i | input | 1 | Reset exception request |
| rq_dabt_i | input | 1 | Data abort request |
| rq_fiq_i | input | 1 | Fast interrupt request |
| rq_irq_i | input | 1 | Normal interrupt request |
| rq_pabt_i | input | 1 | Prefetch abort request for the instruction at the boundary |
| rq_und_i | input | 1 | Undefined instruction request |
| rq_swi_i | input | 1 | Software call request |
| pabt_flush_i | input | 1 | Tagged instruction was flushed, so the prefetch abort is void |
| status_i | input | 32 | Current status word |
| pc_i | input | 32 | Instruction address used to form the return link |
| hi_vec_i | input | 1 | Selects the high vector base |
| entry_o | output | 1 | One-cycle entry pulse |
| new_status_o | output | 32 | Status word after entry |
| saved_status_o | output | 32 | Value for the target saved-status register |
| link_o | output | 32 | Return link value |
| vector_o | output | 32 | Vector address |
| link_we_o | output | 5 | One-hot write strobe for the banked link register |
| psr_we_o | output | 5 | One-hot write strobe for the banked saved-status register |

## Verification
The hardest case to reach is a collision between several requests while the masking bits, the flush flag and the vector select vary. The bench therefore sweeps every legal combination of the seven requests against both mask bits, the flush flag and the vector select, and computes the expected winner and entry fields arithmetically for each one. It also holds a boundary and an interrupt across an entry to show that the following cycle is skipped. A further case presents a data abort together with an unmasked fast interrupt, and the interrupt is then granted at the next boundary.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int WORD_W = 32;
    localparam int BANKS  = 5;

    typedef enum logic [2:0] {
        EXC_NONE = 3'd0,
        EXC_RST  = 3'd1,
        EXC_DABT = 3'd2,
        EXC_FIQ  = 3'd3,
        EXC_IRQ  = 3'd4,
        EXC_PABT = 3'd5,
        EXC_UND  = 3'd6,
        EXC_SWI  = 3'd7
    } exc_kind_e;

    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_FIQ = 5'b10001;

    typedef struct packed {
        logic              entry;
        logic [WORD_W-1:0] new_status;
        logic [WORD_W-1:0] saved_status;
        logic [WORD_W-1:0] link;
        logic [WORD_W-1:0] vector;
        logic [BANKS-1:0]  link_we;
        logic [BANKS-1:0]  psr_we;
    } entry_s;

    function automatic logic [4:0] vec_offset(exc_kind_e k);
        case (k)
            EXC_UND:  return 5'h04;
            EXC_SWI:  return 5'h08;
            EXC_PABT: return 5'h0C;
            EXC_DABT: return 5'h10;
            EXC_IRQ:  return 5'h18;
            EXC_FIQ:  return 5'h1C;
            default:  return 5'h00;
        endcase
    endfunction

    function automatic logic [4:0] mode_code(exc_kind_e k);
        case (k)
            EXC_UND:            return MODE_UND;
            EXC_PABT, EXC_DABT: return MODE_ABT;
            EXC_IRQ:            return MODE_IRQ;
            EXC_FIQ:            return MODE_FIQ;
            default:            return MODE_SVC;
        endcase
    endfunction

    function automatic logic [BANKS-1:0] bank_sel(exc_kind_e k);
        case (k)
            EXC_SWI:            return 5'b00001;
            EXC_UND:            return 5'b00010;
            EXC_PABT, EXC_DABT: return 5'b00100;
            EXC_IRQ:            return 5'b01000;
            EXC_FIQ:            return 5'b10000;
            default:            return 5'b00000;
        endcase
    endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      enable_i,
    input  logic      bnd_i,
    input  logic      rst_rq_i,
    input  logic      dabt_rq_i,
    input  logic      fiq_rq_i,
    input  logic      irq_rq_i,
    input  logic      pabt_rq_i,
    input  logic      und_rq_i,
    input  logic      swi_rq_i,
    input  logic      flush_i,
    input  logic      fiq_dis_i,
    input  logic      irq_dis_i,
    output exc_kind_e grant_o
);
    logic fiq_ok, irq_ok, pabt_ok;

    always_comb begin
        fiq_ok  = fiq_rq_i & ~fiq_dis_i;
        irq_ok  = irq_rq_i & ~irq_dis_i;
        pabt_ok = pabt_rq_i & ~flush_i;
        grant_o = EXC_NONE;
        if (enable_i) begin
            if (rst_rq_i)                grant_o = EXC_RST;
            else if (bnd_i && dabt_rq_i) grant_o = EXC_DABT;
            else if (bnd_i && fiq_ok)    grant_o = EXC_FIQ;
            else if (bnd_i && irq_ok)    grant_o = EXC_IRQ;
            else if (bnd_i && pabt_ok)   grant_o = EXC_PABT;
            else if (bnd_i && und_rq_i)  grant_o = EXC_UND;
            else if (bnd_i && swi_rq_i)  grant_o = EXC_SWI;
        end
    end
endmodule

// File: rtl/exc_update.sv
module exc_update
    import exc_pkg::*;
#(
    parameter logic [WORD_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  exc_kind_e         kind_i,
    input  logic [WORD_W-1:0] status_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic              hi_vec_i,
    output entry_s            upd_o
);
    localparam logic [WORD_W-1:0] LINK_NEAR = WORD_W'(4);
    localparam logic [WORD_W-1:0] LINK_FAR  = WORD_W'(8);

    logic [WORD_W-1:0] base;

    always_comb begin
        base = hi_vec_i ? HI_BASE : '0;
        upd_o = '0;
        upd_o.entry = 1'b1;
        upd_o.saved_status = status_i;
        upd_o.new_status = status_i;
        upd_o.new_status[4:0] = mode_code(kind_i);
        upd_o.new_status[5] = 1'b0;
        upd_o.new_status[7] = 1'b1;
        if (kind_i == EXC_RST || kind_i == EXC_FIQ)
            upd_o.new_status[6] = 1'b1;
        upd_o.link = pc_i + ((kind_i == EXC_DABT) ? LINK_FAR : LINK_NEAR);
        upd_o.vector = base | {{(WORD_W-5){1'b0}}, vec_offset(kind_i)};
        upd_o.link_we = bank_sel(kind_i);
        upd_o.psr_we = bank_sel(kind_i);
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter logic [WORD_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              rq_reset_i,
    input  logic              rq_dabt_i,
    input  logic              rq_fiq_i,
    input  logic              rq_irq_i,
    input  logic              rq_pabt_i,
    input  logic              rq_und_i,
    input  logic              rq_swi_i,
    input  logic              pabt_flush_i,
    input  logic [WORD_W-1:0] status_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic              hi_vec_i,
    output logic              entry_o,
    output logic [WORD_W-1:0] new_status_o,
    output logic [WORD_W-1:0] saved_status_o,
    output logic [WORD_W-1:0] link_o,
    output logic [WORD_W-1:0] vector_o,
    output logic [BANKS-1:0]  link_we_o,
    output logic [BANKS-1:0]  psr_we_o
);
    entry_s    cur_q, nxt_d, upd;
    exc_kind_e grant;

    exc_arbiter i_arb (
        .enable_i  (~cur_q.entry),
        .bnd_i     (boundary_i),
        .rst_rq_i  (rq_reset_i),
        .dabt_rq_i (rq_dabt_i),
        .fiq_rq_i  (rq_fiq_i),
        .irq_rq_i  (rq_irq_i),
        .pabt_rq_i (rq_pabt_i),
        .und_rq_i  (rq_und_i),
        .swi_rq_i  (rq_swi_i),
        .flush_i   (pabt_flush_i),
        .fiq_dis_i (status_i[6]),
        .irq_dis_i (status_i[7]),
        .grant_o   (grant)
    );

    exc_update #(.HI_BASE(HI_BASE)) i_upd (
        .kind_i   (grant),
        .status_i (status_i),
        .pc_i     (pc_i),
        .hi_vec_i (hi_vec_i),
        .upd_o    (upd)
    );

    always_comb begin
        nxt_d = cur_q;
        nxt_d.entry = 1'b0;
        nxt_d.link_we = '0;
        nxt_d.psr_we = '0;
        if (grant != EXC_NONE)
            nxt_d = upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign entry_o        = cur_q.entry;
    assign new_status_o   = cur_q.new_status;
    assign saved_status_o = cur_q.saved_status;
    assign link_o         = cur_q.link;
    assign vector_o       = cur_q.vector;
    assign link_we_o      = cur_q.link_we;
    assign psr_we_o       = cur_q.psr_we;

    // R10
    entry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |=> !entry_o);
    // R2
    no_rsvd_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> vector_o[4:0] != 5'h14);
    // R4
    status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> (new_status_o[7] && !new_status_o[5]));
    // R9
    we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_we_o) && link_we_o == psr_we_o);
    // R8
    reset_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_o && vector_o[4:0] == 5'h00) |-> (link_we_o == '0));
    // R6
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == EXC_IRQ) |-> !status_i[7]);
    // R10
    quiet_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_o |-> (link_we_o == '0 && psr_we_o == '0));
endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0;
    logic        rq_reset_i = 1'b0, rq_dabt_i = 1'b0, rq_fiq_i = 1'b0, rq_irq_i = 1'b0;
    logic        rq_pabt_i = 1'b0, rq_und_i = 1'b0, rq_swi_i = 1'b0;
    logic        pabt_flush_i = 1'b0;
    logic [31:0] status_i = '0, pc_i = '0;
    logic        hi_vec_i = 1'b0;
    logic        entry_o;
    logic [31:0] new_status_o, saved_status_o, link_o, vector_o;
    logic [4:0]  link_we_o, psr_we_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
        .rq_reset_i(rq_reset_i), .rq_dabt_i(rq_dabt_i), .rq_fiq_i(rq_fiq_i),
        .rq_irq_i(rq_irq_i), .rq_pabt_i(rq_pabt_i), .rq_und_i(rq_und_i),
        .rq_swi_i(rq_swi_i), .pabt_flush_i(pabt_flush_i), .status_i(status_i),
        .pc_i(pc_i), .hi_vec_i(hi_vec_i), .entry_o(entry_o),
        .new_status_o(new_status_o), .saved_status_o(saved_status_o),
        .link_o(link_o), .vector_o(vector_o), .link_we_o(link_we_o),
        .psr_we_o(psr_we_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        boundary_i = 0; rq_reset_i = 0; rq_dabt_i = 0; rq_fiq_i = 0; rq_irq_i = 0;
        rq_pabt_i = 0; rq_und_i = 0; rq_swi_i = 0; pabt_flush_i = 0;
    endtask

    // kinds: 0 none,1 reset,2 dabt,3 fiq,4 irq,5 pabt,6 und,7 swi
    function automatic int pick(logic [6:0] r, logic fl, logic [31:0] st, logic bnd);
        if (r[0]) return 1;
        if (!bnd) return 0;
        if (r[1]) return 2;
        if (r[2] && !st[6]) return 3;
        if (r[3] && !st[7]) return 4;
        if (r[4] && !fl) return 5;
        if (r[5]) return 6;
        if (r[6]) return 7;
        return 0;
    endfunction

    function automatic logic [31:0] exp_vec(int k, logic hv);
        logic [31:0] off;
        case (k)
            6: off = 32'h04; 7: off = 32'h08; 5: off = 32'h0C;
            2: off = 32'h10; 4: off = 32'h18; 3: off = 32'h1C;
            default: off = 32'h00;
        endcase
        return (hv ? 32'hFFFF_0000 : 32'h0) + off;
    endfunction

    function automatic logic [31:0] exp_st(int k, logic [31:0] st);
        logic [31:0] s = st;
        case (k)
            6: s[4:0] = 5'b11011;
            2, 5: s[4:0] = 5'b10111;
            4: s[4:0] = 5'b10010;
            3: s[4:0] = 5'b10001;
            default: s[4:0] = 5'b10011;
        endcase
        s[5] = 1'b0; s[7] = 1'b1;
        if (k == 1 || k == 3) s[6] = 1'b1;
        return s;
    endfunction

    function automatic logic [31:0] exp_we(int k);
        case (k)
            7: return 32'h01; 6: return 32'h02; 2, 5: return 32'h04;
            4: return 32'h08; 3: return 32'h10; default: return 32'h00;
        endcase
    endfunction

    task automatic apply(logic [6:0] r, logic fl, logic hv, logic [31:0] st,
                         logic [31:0] pc, logic bnd);
        int k;
        @(negedge clk);
        {rq_swi_i, rq_und_i, rq_pabt_i, rq_irq_i, rq_fiq_i, rq_dabt_i, rq_reset_i} = r;
        pabt_flush_i = fl; hi_vec_i = hv; status_i = st; pc_i = pc; boundary_i = bnd;
        k = pick(r, fl, st, bnd);
        @(negedge clk);
        clear_in();
        if (k == 0) begin
            chk("R10 idle entry", {31'b0, entry_o}, 32'h0);
            chk("R10 idle strobes", {22'b0, link_we_o, psr_we_o}, 32'h0);
        end else begin
            chk("R1 R6 R7 entry", {31'b0, entry_o}, 32'h1);
            chk("R2 vector", vector_o, exp_vec(k, hv));
            chk("R3 R4 status", new_status_o, exp_st(k, st));
            chk("R9 saved", saved_status_o, st);
            if (k != 1) chk("R5 link", link_o, pc + ((k == 2) ? 32'd8 : 32'd4));
            chk("R8 R9 link_we", {27'b0, link_we_o}, exp_we(k));
            chk("R9 psr_we", {27'b0, psr_we_o}, exp_we(k));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        boundary_i = 1; rq_irq_i = 1;
        @(negedge clk);
        chk("R11 entry in reset", {31'b0, entry_o}, 32'h0);
        chk("R11 strobes in reset", {22'b0, link_we_o, psr_we_o}, 32'h0);
        clear_in();
        rst_n = 1;
        @(negedge clk);
        chk("R11 entry after reset", {31'b0, entry_o}, 32'h0);

        // R1..R7 R9 sweep
        for (int m = 0; m < 4; m++)
            for (int hv = 0; hv < 2; hv++)
                for (int fl = 0; fl < 2; fl++)
                    for (int r = 0; r < 128; r++) begin
                        logic [31:0] st;
                        if (r[5] && r[6]) continue;
                        st = 32'hA5C3_0030 | (32'(m) << 6);
                        apply(7'(r), fl[0], hv[0], st, 32'h0000_1000 + 32'(r * 16), 1'b1);
                    end

        // R8: reset request without a boundary; other requests ignored
        apply(7'b0000001, 1'b0, 1'b1, 32'h0000_00D0, 32'h40, 1'b0);
        apply(7'b0000100, 1'b0, 1'b0, 32'h0000_0010, 32'h40, 1'b0);

        // R10: boundary held through entry is ignored in the entry cycle
        @(negedge clk);
        boundary_i = 1; rq_irq_i = 1; status_i = 32'h10; pc_i = 32'h200;
        @(negedge clk);
        chk("R10 first entry", {31'b0, entry_o}, 32'h1);
        @(negedge clk);
        chk("R10 skipped cycle", {31'b0, entry_o}, 32'h0);
        @(negedge clk);
        chk("R10 re-entry", {31'b0, entry_o}, 32'h1);
        clear_in();
        @(negedge clk);

        // R1: data abort wins over fast interrupt, interrupt taken next
        apply(7'b0000110, 1'b0, 1'b0, 32'h10, 32'h300, 1'b1);
        apply(7'b0000100, 1'b0, 1'b0, 32'h90, 32'h304, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule